// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from a set of sources and drives two active-low request lines toward a processor: a fast line, `fiq_n`, and a normal line, `irq_n`. Source 0 is the fast source. It goes straight to `fiq_n` and never enters the priority logic. Sources 1 and up are the three external request lines followed by the on-chip peripheral requests. Each of these has a 3-bit priority level, an 8-bit vector, and a choice of edge or level sensing. Each source also has its own enable bit.

Software finds the winning source by reading one vector register. It never has to decode source numbers. In normal operation the read acknowledges the winner: the winner's level is pushed onto an in-service stack, and the winner's edge latch is cleared. A write to an end-of-interrupt register pops the stack, so nesting follows priority. When nothing qualifies, the read returns a programmable spurious vector. A protect mode makes the vector read free of side effects, so a debugger can inspect the controller safely. In that mode a later write to the vector register performs the acknowledge.

The register port is a plain single-cycle interface with no back-pressure. Any access completes in the cycle it is presented. Read data is combinational from the address, and side effects take place on the clock edge that ends the access.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset `irq_n` and `fiq_n` are 1, every enable bit is 0, the in-service stack is empty, and the spurious vector register (address 0x15) reads 0x00FF.
- R2: A write to address i (i below N_SRC, address bit 4 clear) sets the configuration of source i: priority in bits 2:0, edge sensing in bit 3 (1 = edge), vector in bits 11:4. Reading the same address returns those fields, with bits 15:12 read as 0.
- R3: A write to 0x10 sets the enable bits given by 1s in the data, and a write to 0x11 clears them. Address 0x12 reads the enables. A source whose enable bit is 0 never causes `irq_n` or `fiq_n` to go low.
- R4: A source in edge mode latches a rising edge of its line. It stays pending (address 0x17, bit i) after the line falls, until it is acknowledged or cleared by a write of a 1 in bit i to 0x18. A level-mode source is pending exactly while its line is high.
- R5: `irq_n` is 0 when an enabled, pending source from 1 upward exists whose priority is strictly greater than the top of the in-service stack, or when such a source exists and the stack is empty.
- R6: A read of 0x13 returns the vector of the qualifying source with the highest priority. When priorities tie, the lowest source number wins.
- R7: With protect mode off, a read of 0x13 that finds a qualifying source pushes its priority onto the stack and clears its edge latch. Sources at or below that priority then stop driving `irq_n`. The stack never holds more than 8 entries.
- R8: A write to 0x14 (end of interrupt) pops one stack entry, which restores the previous in-service level.
- R9: A read of 0x13 with no qualifying source returns the spurious vector and pushes nothing. The spurious vector is written at 0x15 (bits 7:0).
- R10: With protect mode on (0x16 bit 0 = 1), a read of 0x13 changes neither the stack nor any pending bit. A write to 0x13 performs the acknowledge instead.
- R11: `fiq_n` is 0 exactly while source 0 is pending and enabled, regardless of priorities or the stack. Source 0 is never returned as a vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_src | input | N_SRC | Raw interrupt lines, active high; bit 0 is the fast source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (triggers read side effects) |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_n | output | 1 | Normal interrupt request, active low |
| fiq_n | output | 1 | Fast interrupt request, active low |

## Verification
The bound checker watches several properties on every cycle. It checks that the outputs are idle after reset and that nothing fires while all enables are clear. It checks that each acknowledging read grows the in-service stack by exactly one and each end-of-interrupt write shrinks it by one. It also checks that a full stack silences `irq_n`, that a read with no candidate returns the spurious vector, and that a protected read leaves the stack alone. Some behaviour can only be shown by the directed scenarios, because it needs a chosen history. These are the choice of winner among several priorities, lowest-index tie breaking, nested service that resumes a lower level after end-of-interrupt, and edge latches that outlive their pulse. The scenarios also cover register readback with ignored upper bits and pending bits that a protected read must not clear.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int PRIO_W = 3;
  localparam int VEC_W  = 8;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_EN_SET = 5'h10;
  localparam logic [ADDR_W-1:0] A_EN_CLR = 5'h11;
  localparam logic [ADDR_W-1:0] A_EN_RD  = 5'h12;
  localparam logic [ADDR_W-1:0] A_VECTOR = 5'h13;
  localparam logic [ADDR_W-1:0] A_EOI    = 5'h14;
  localparam logic [ADDR_W-1:0] A_SPUR   = 5'h15;
  localparam logic [ADDR_W-1:0] A_CTRL   = 5'h16;
  localparam logic [ADDR_W-1:0] A_PEND   = 5'h17;
  localparam logic [ADDR_W-1:0] A_PCLR   = 5'h18;

  typedef struct packed {
    logic [VEC_W-1:0]  vec;
    logic              edge_mode;
    logic [PRIO_W-1:0] prio;
  } src_cfg_t;

  localparam int CFG_W = $bits(src_cfg_t);
endpackage

// File: rtl/ivc_detect.sv
module ivc_detect #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_in,
  input  logic [N_SRC-1:0] edge_mode,
  input  logic [N_SRC-1:0] clr,
  output logic [N_SRC-1:0] pend
);
  logic [N_SRC-1:0] src_q, src_d, edge_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      src_d  <= '0;
      edge_q <= '0;
    end else begin
      src_q  <= src_in;
      src_d  <= src_q;
      // a fresh edge wins over a clear in the same cycle
      edge_q <= (edge_q & ~clr) | (src_q & ~src_d);
    end
  end

  assign pend = (edge_mode & edge_q) | (~edge_mode & src_q);
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter import ivc_pkg::*; #(
  parameter int N_SRC = 8,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]        req,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  input  logic                    lvl_valid,
  input  logic [PRIO_W-1:0]       lvl,
  output logic                    hit,
  output logic [IDX_W-1:0]        win_idx
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    hit     = 1'b0;
    best    = '0;
    win_idx = '0;
    // index 0 is the fast source and stays out of the arbitration
    for (int i = 1; i < N_SRC; i++) begin
      if (req[i] &&
          (!lvl_valid || prio_flat[i*PRIO_W +: PRIO_W] > lvl) &&
          (!hit || prio_flat[i*PRIO_W +: PRIO_W] > best)) begin
        hit     = 1'b1;
        best    = prio_flat[i*PRIO_W +: PRIO_W];
        win_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ivc_stack.sv
module ivc_stack #(
  parameter int W     = 3,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic             empty,
  output logic             full,
  output logic [W-1:0]     top,
  output logic [CNT_W-1:0] cnt
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      unique case ({push, pop})
        2'b10: if (!full) begin
          mem[PTR_W'(cnt)] <= din;
          cnt <= cnt + 1'b1;
        end
        2'b01: if (!empty) cnt <= cnt - 1'b1;
        2'b11: if (!empty) mem[PTR_W'(cnt - 1'b1)] <= din;
               else begin
                 mem[0] <= din;
                 cnt    <= CNT_W'(1);
               end
        default: ;
      endcase
    end
  end

  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));
  assign top   = empty ? '0 : mem[PTR_W'(cnt - 1'b1)];
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl import ivc_pkg::*; #(
  parameter int               N_SRC    = 8,
  parameter logic [VEC_W-1:0] SPUR_RST = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_src,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_n,
  output logic              fiq_n
);
  localparam int IDX_W = $clog2(N_SRC);
  localparam int DEPTH = 1 << PRIO_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  src_cfg_t                cfg_q [N_SRC];
  logic [N_SRC-1:0]        en_q, pend, mode_vec, clr_vec, req;
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic [VEC_W-1:0]        spur_q;
  logic                    protect_q;
  logic                    hit, ack, eoi_wr, vec_rd, vec_wr, cfg_sel;
  logic [IDX_W-1:0]        win_idx;
  logic                    stk_empty, stk_full;
  logic [PRIO_W-1:0]       stk_top;
  logic [CNT_W-1:0]        stk_cnt;

  assign cfg_sel = !bus_addr[ADDR_W-1] && (int'(bus_addr[ADDR_W-2:0]) < N_SRC);
  assign vec_rd  = bus_rd && (bus_addr == A_VECTOR);
  assign vec_wr  = bus_wr && (bus_addr == A_VECTOR);
  assign eoi_wr  = bus_wr && (bus_addr == A_EOI);
  assign ack     = hit && (protect_q ? vec_wr : vec_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SRC; i++) cfg_q[i] <= '0;
      en_q      <= '0;
      spur_q    <= SPUR_RST;
      protect_q <= 1'b0;
    end else if (bus_wr) begin
      if (cfg_sel) cfg_q[bus_addr[IDX_W-1:0]] <= src_cfg_t'(bus_wdata[CFG_W-1:0]);
      unique case (bus_addr)
        A_EN_SET: en_q      <= en_q | bus_wdata[N_SRC-1:0];
        A_EN_CLR: en_q      <= en_q & ~bus_wdata[N_SRC-1:0];
        A_SPUR:   spur_q    <= bus_wdata[VEC_W-1:0];
        A_CTRL:   protect_q <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_flat
    assign prio_flat[g*PRIO_W +: PRIO_W] = cfg_q[g].prio;
    assign mode_vec[g] = cfg_q[g].edge_mode;
    assign clr_vec[g]  = (bus_wr && bus_addr == A_PCLR && bus_wdata[g]) ||
                         (ack && win_idx == IDX_W'(g));
  end

  ivc_detect #(.N_SRC(N_SRC)) u_detect (
    .clk(clk), .rst_n(rst_n), .src_in(irq_src), .edge_mode(mode_vec),
    .clr(clr_vec), .pend(pend)
  );

  assign req = pend & en_q;

  ivc_arbiter #(.N_SRC(N_SRC)) u_arb (
    .req(req), .prio_flat(prio_flat), .lvl_valid(!stk_empty), .lvl(stk_top),
    .hit(hit), .win_idx(win_idx)
  );

  ivc_stack #(.W(PRIO_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(ack), .pop(eoi_wr),
    .din(cfg_q[win_idx].prio), .empty(stk_empty), .full(stk_full),
    .top(stk_top), .cnt(stk_cnt)
  );

  assign irq_n = !hit;
  assign fiq_n = !req[0];

  always_comb begin
    bus_rdata = '0;
    if (cfg_sel) bus_rdata = DATA_W'(cfg_q[bus_addr[IDX_W-1:0]]);
    else begin
      unique case (bus_addr)
        A_EN_RD:  bus_rdata = DATA_W'(en_q);
        A_VECTOR: bus_rdata = hit ? DATA_W'(cfg_q[win_idx].vec) : DATA_W'(spur_q);
        A_SPUR:   bus_rdata = DATA_W'(spur_q);
        A_CTRL:   bus_rdata = DATA_W'(protect_q);
        A_PEND:   bus_rdata = DATA_W'(pend);
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk import ivc_pkg::*; #(
  parameter int N_SRC = 8,
  localparam int DEPTH = 1 << PRIO_W,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_n,
  input logic              fiq_n,
  input logic [N_SRC-1:0]  en_q,
  input logic [CNT_W-1:0]  stk_cnt,
  input logic              stk_full,
  input logic              push,
  input logic              eoi_wr,
  input logic              vec_rd,
  input logic              vec_wr,
  input logic              protect_q,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [VEC_W-1:0]  spur_q
);
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (irq_n && fiq_n));

  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (irq_n && fiq_n));

  p_ack_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !protect_q && !irq_n && !eoi_wr) |=> stk_cnt == $past(stk_cnt) + 1'b1);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |-> irq_n);

  p_eoi_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && stk_cnt != '0 && !push) |=> stk_cnt == $past(stk_cnt) - 1'b1);

  p_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && irq_n) |-> bus_rdata == DATA_W'(spur_q));

  p_protect_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && protect_q && !vec_wr && !eoi_wr) |=> $stable(stk_cnt));

  p_fiq_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[0] |-> fiq_n);
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .fiq_n(fiq_n), .en_q(en_q),
  .stk_cnt(stk_cnt), .stk_full(stk_full), .push(ack), .eoi_wr(eoi_wr),
  .vec_rd(vec_rd), .vec_wr(vec_wr), .protect_q(protect_q),
  .bus_rdata(bus_rdata), .spur_q(spur_q)
);

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_src = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_n, fiq_n;
  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  vec_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_n(irq_n), .fiq_n(fiq_n)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 20000", cycles);
      summary();
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic lines(logic [7:0] v);
    @(negedge clk);
    irq_src = v;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [15:0] cfgw(logic [2:0] p, logic e, logic [7:0] v);
    return {4'h0, v, e, p};
  endfunction

  task automatic t_reset();
    logic [15:0] d;
    @(negedge clk);
    chk("R1 irq_n", 16'(irq_n), 16'h1);
    chk("R1 fiq_n", 16'(fiq_n), 16'h1);
    rd(5'h12, d); chk("R1 enables", d, 16'h0000);
    rd(5'h15, d); chk("R1 spurious", d, 16'h00FF);
    rd(5'h13, d); chk("R9 idle vector", d, 16'h00FF);
  endtask

  task automatic t_config();
    logic [15:0] d;
    wr(5'h04, 16'hF000 | cfgw(3'd3, 1'b0, 8'h44));
    rd(5'h04, d); chk("R2 cfg4 readback", d, cfgw(3'd3, 1'b0, 8'h44));
    wr(5'h02, cfgw(3'd1, 1'b1, 8'h22));
    rd(5'h02, d); chk("R2 cfg2 readback", d, cfgw(3'd1, 1'b1, 8'h22));
    wr(5'h01, cfgw(3'd2, 1'b0, 8'h11));
    wr(5'h03, cfgw(3'd4, 1'b0, 8'h33));
    wr(5'h05, cfgw(3'd3, 1'b0, 8'h55));
    wr(5'h06, cfgw(3'd5, 1'b0, 8'h66));
    wr(5'h07, cfgw(3'd6, 1'b0, 8'h77));
    wr(5'h00, cfgw(3'd0, 1'b1, 8'h00));
  endtask

  task automatic t_mask();
    logic [15:0] d;
    lines(8'h08);
    chk("R3 masked no irq", 16'(irq_n), 16'h1);
    wr(5'h10, 16'h0008);
    rd(5'h12, d); chk("R3 enable set", d, 16'h0008);
    chk("R5 enabled level irq", 16'(irq_n), 16'h0);
    wr(5'h11, 16'h0008);
    rd(5'h12, d); chk("R3 enable clear", d, 16'h0000);
    chk("R3 cleared no irq", 16'(irq_n), 16'h1);
    lines(8'h00);
  endtask

  task automatic t_edge();
    logic [15:0] d;
    wr(5'h10, 16'h000C);
    lines(8'h04); lines(8'h00);
    rd(5'h17, d); chk("R4 edge held", d & 16'h0004, 16'h0004);
    chk("R5 edge irq", 16'(irq_n), 16'h0);
    rd(5'h13, d); chk("R6 edge vector", d, 16'h0022);
    rd(5'h17, d); chk("R7 ack clears edge", d & 16'h0004, 16'h0000);
    wr(5'h14, 16'h0);
    lines(8'h04); lines(8'h00);
    wr(5'h18, 16'h0004);
    rd(5'h17, d); chk("R4 clear reg", d & 16'h0004, 16'h0000);
    chk("R4 no irq after clear", 16'(irq_n), 16'h1);
    lines(8'h08);
    rd(5'h17, d); chk("R4 level pend", d & 16'h0008, 16'h0008);
    lines(8'h00);
    rd(5'h17, d); chk("R4 level drop", d & 16'h0008, 16'h0000);
    wr(5'h11, 16'h000C);
  endtask

  task automatic t_priority();
    logic [15:0] d;
    wr(5'h10, 16'h00F0);
    lines(8'h70);
    rd(5'h13, d); chk("R6 highest wins", d, 16'h0066);
    chk("R7 lower held off", 16'(irq_n), 16'h1);
    lines(8'h30);
    wr(5'h14, 16'h0);
    chk("R8 resume after pop", 16'(irq_n), 16'h0);
    rd(5'h13, d); chk("R6 tie lowest index", d, 16'h0044);
    chk("R5 equal level blocked", 16'(irq_n), 16'h1);
    lines(8'hB0);
    chk("R5 higher nests", 16'(irq_n), 16'h0);
    rd(5'h13, d); chk("R6 nested vector", d, 16'h0077);
    wr(5'h14, 16'h0);
    @(negedge clk);
    chk("R8 pop to level 3", 16'(irq_n), 16'h0);
    lines(8'h30);
    chk("R8 level 3 blocks", 16'(irq_n), 16'h1);
    wr(5'h14, 16'h0);
    @(negedge clk);
    chk("R8 empty stack irq", 16'(irq_n), 16'h0);
    lines(8'h00);
    wr(5'h11, 16'h00F0);
    chk("R3 all off", 16'(irq_n), 16'h1);
  endtask

  task automatic t_spurious();
    logic [15:0] d;
    wr(5'h15, 16'h003C);
    rd(5'h13, d); chk("R9 new spurious", d, 16'h003C);
    wr(5'h10, 16'h0010);
    lines(8'h10);
    rd(5'h13, d); chk("R6 single source", d, 16'h0044);
    rd(5'h13, d); chk("R9 spurious in service", d, 16'h003C);
    wr(5'h14, 16'h0);
    @(negedge clk);
    chk("R9 no extra push", 16'(irq_n), 16'h0);
    lines(8'h00);
    wr(5'h11, 16'h0010);
  endtask

  task automatic t_protect();
    logic [15:0] d;
    wr(5'h10, 16'h0006);
    wr(5'h16, 16'h0001);
    lines(8'h02);
    rd(5'h13, d); chk("R10 protected read", d, 16'h0011);
    chk("R10 still requesting", 16'(irq_n), 16'h0);
    rd(5'h13, d); chk("R10 repeat read", d, 16'h0011);
    wr(5'h13, 16'h0);
    @(negedge clk);
    chk("R10 write acks", 16'(irq_n), 16'h1);
    wr(5'h14, 16'h0);
    @(negedge clk);
    chk("R8 pop after protected ack", 16'(irq_n), 16'h0);
    lines(8'h00);
    lines(8'h04); lines(8'h00);
    rd(5'h13, d); chk("R10 edge vector", d, 16'h0022);
    rd(5'h17, d); chk("R10 pend kept", d & 16'h0004, 16'h0004);
    wr(5'h18, 16'h0004);
    wr(5'h16, 16'h0000);
    wr(5'h11, 16'h0006);
  endtask

  task automatic t_fiq();
    logic [15:0] d;
    lines(8'h01); lines(8'h00);
    chk("R11 masked fiq", 16'(fiq_n), 16'h1);
    wr(5'h10, 16'h0001);
    chk("R11 fiq low", 16'(fiq_n), 16'h0);
    chk("R11 irq untouched", 16'(irq_n), 16'h1);
    rd(5'h13, d); chk("R11 not vectored", d, 16'h003C);
    wr(5'h18, 16'h0001);
    @(negedge clk);
    chk("R11 fiq cleared", 16'(fiq_n), 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_config();
    t_mask();
    t_edge();
    t_priority();
    t_spurious();
    t_protect();
    t_fiq();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule